// File: doc/BRIEF.md
# Misaligned Data Access Trap Detector

This block watches the load/store stream of a processor pipeline. On each cycle with a valid access it compares the low address bits against a size mask: 0 for a byte, 1 for a halfword and 3 for a word. An access whose address has any of the masked bits set is misaligned. When a misaligned access is seen, the block records the whole faulting address. It also builds an exception status word that carries a fixed cause code, the destination register index, the direction of the access and a flag for word-sized accesses.

The status word uses fixed bit positions, because the trap-handling logic downstream decodes it. The two captured registers are loaded for every misaligned access. The trap request to the exception sequencer is raised only while the exception-enable input is high. With exceptions disabled, software can still read the captured address and status afterwards. The bus access itself and the vectoring to a handler belong to other blocks.

The asynchronous active-low reset is released synchronously inside the block. Results appear one clock after the access is presented.

Top module: `ua_detect`

## Requirements
- R1: An access presented with `acc_valid` high is misaligned exactly when `acc_addr[1:0] & acc_mask` is nonzero. Only a misaligned access loads the capture registers, and only a misaligned access can raise `exc_req`.
- R2: On a misaligned access, `fault_addr` holds the full faulting address from the following clock edge onward.
- R3: `fault_status` is laid out as follows. Bits [4:0] hold the cause code 5'h01. Bits [9:5] hold the register index. Bit 10 holds the write flag (1 means store). All bits above 11 are zero.
- R4: Bit 11 of `fault_status` is 1 when the misaligned access used mask 3 (word). It is 0 for any other mask.
- R5: `exc_req` is raised only when `exc_enable` was high during the misaligned access. `fault_addr` and `fault_status` are updated whether or not `exc_enable` is high.
- R6: An access with mask 0 (byte) never counts as misaligned, whatever its address.
- R7: `exc_req` is high for exactly the one cycle after each enabled misaligned access. The capture registers keep their values through aligned accesses and idle cycles until the next misaligned access.
- R8: While reset is asserted, and until the first misaligned access after it, `fault_addr`, `fault_status` and `exc_req` are all zero.
- R9: An access with `acc_valid` low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load/store is presented this cycle |
| acc_addr | input | 32 | Effective address of the access |
| acc_mask | input | 2 | Alignment mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_reg | input | 5 | Destination/source register index |
| exc_enable | input | 1 | Exceptions enabled |
| fault_addr | output | 32 | Captured faulting address |
| fault_status | output | 32 | Exception status word |
| exc_req | output | 1 | One-cycle trap request |

## Verification
The bench sends a word access at each of the three unaligned offsets, halfword accesses at odd and even addresses, and a byte access at an all-ones address. A design with the wrong mask test would raise a trap on an aligned access or on the byte access, or would miss an offset. It runs a misaligned access with exceptions disabled. A design that gates the capture registers with the enable would show stale address and status there, and one that ignores the enable would raise a request. It sends back-to-back misaligned accesses followed by idle, aligned and invalid cycles. A design that stretches the request, or that lets non-faulting cycles overwrite or clear the captured values, shows up as a mismatch against the scoreboard. Store/load and word/halfword combinations with extreme register indices expose any misplaced status field.

// File: rtl/ua_pkg.sv
package ua_pkg;
  // Status word field positions, fixed because the trap handler decodes them.
  localparam int CAUSE_W      = 5;
  localparam int CAUSE_LSB    = 0;
  localparam int REG_W        = 5;
  localparam int REG_LSB      = 5;
  localparam int WRITE_BIT    = 10;
  localparam int WORD_BIT     = 11;
  localparam int STATUS_MIN_W = WORD_BIT + 1;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGNED = 5'h01;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd3
  } size_mask_e;
endpackage

// File: rtl/ua_rst_sync.sv
module ua_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/ua_align_check.sv
module ua_align_check
  import ua_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] mask,
  input  logic          valid,
  output logic          misaligned,
  output logic          word_acc
);
  localparam logic [MW-1:0] WORD_MASK = MW'(SZ_WORD);

  logic [MW-1:0] low_bits;
  logic [MW-1:0] hit_bits;

  // One AND per low address bit.
  for (genvar i = 0; i < MW; i++) begin : g_bit
    assign low_bits[i] = addr[i];
    assign hit_bits[i] = low_bits[i] & mask[i];
  end

  always_comb begin
    misaligned = valid && (|hit_bits);
    word_acc   = (mask == WORD_MASK);
  end
endmodule

// File: rtl/ua_status_pack.sv
module ua_status_pack
  import ua_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic             is_write,
  input  logic [REG_W-1:0] reg_idx,
  input  logic             word_acc,
  output logic [SW-1:0]    status
);
  always_comb begin
    status = '0;
    status[CAUSE_LSB +: CAUSE_W] = CAUSE_MISALIGNED;
    status[REG_LSB +: REG_W]     = reg_idx;
    status[WRITE_BIT]            = is_write;
    status[WORD_BIT]             = word_acc;
  end
endmodule

// File: rtl/ua_capture.sv
module ua_capture #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          hit,
  input  logic          enable,
  input  logic [AW-1:0] addr_in,
  input  logic [SW-1:0] status_in,
  output logic [AW-1:0] addr_q,
  output logic [SW-1:0] status_q,
  output logic          req_q
);
  logic [AW-1:0] addr_d;
  logic [SW-1:0] status_d;
  logic          req_d;
  logic          load_en;
  logic          past_ok;

  always_comb begin
    load_en  = hit;
    addr_d   = load_en ? addr_in   : addr_q;
    status_d = load_en ? status_in : status_q;
    req_d    = hit & enable;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q   <= '0;
      status_q <= '0;
      req_q    <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      status_q <= status_d;
      req_q    <= req_d;
      past_ok  <= 1'b1;
    end
  end

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && $past(hit) |-> addr_q == $past(addr_in));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && !$past(hit) |-> $stable(addr_q) && $stable(status_q));

  p_req_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && req_q |-> $past(hit));
endmodule

// File: rtl/ua_detect.sv
module ua_detect
  import ua_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32,
  parameter int MW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic [MW-1:0]    acc_mask,
  input  logic             acc_write,
  input  logic [REG_W-1:0] acc_reg,
  input  logic             exc_enable,
  output logic [AW-1:0]    fault_addr,
  output logic [SW-1:0]    fault_status,
  output logic             exc_req
);
  localparam logic [MW-1:0] WORD_MASK = MW'(SZ_WORD);

  logic          rst_sn;
  logic          misaligned;
  logic          word_acc;
  logic [SW-1:0] status_new;
  logic          past_ok;

  ua_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ua_align_check #(.AW(AW), .MW(MW)) u_chk (
    .addr       (acc_addr),
    .mask       (acc_mask),
    .valid      (acc_valid),
    .misaligned (misaligned),
    .word_acc   (word_acc)
  );

  ua_status_pack #(.SW(SW)) u_pack (
    .is_write (acc_write),
    .reg_idx  (acc_reg),
    .word_acc (word_acc),
    .status   (status_new)
  );

  ua_capture #(.AW(AW), .SW(SW)) u_cap (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .hit       (misaligned),
    .enable    (exc_enable),
    .addr_in   (acc_addr),
    .status_in (status_new),
    .addr_q    (fault_addr),
    .status_q  (fault_status),
    .req_q     (exc_req)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_cause_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    exc_req |-> fault_status[CAUSE_LSB +: CAUSE_W] == CAUSE_MISALIGNED);

  p_word_flag_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && exc_req |-> fault_status[WORD_BIT] == ($past(acc_mask) == WORD_MASK));

  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok && exc_req |-> $past(exc_enable));

  p_byte_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_valid && acc_mask == '0 |=> !exc_req);

  p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !acc_valid |=> !exc_req && $stable(fault_addr) && $stable(fault_status));
endmodule

// File: tb/ua_detect_test.sv
module ua_detect_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_mask;
  logic        acc_write;
  logic [4:0]  acc_reg;
  logic        exc_enable;
  logic [31:0] fault_addr;
  logic [31:0] fault_status;
  logic        exc_req;

  always #10 clk = ~clk;

  ua_detect uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_mask     (acc_mask),
    .acc_write    (acc_write),
    .acc_reg      (acc_reg),
    .exc_enable   (exc_enable),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .exc_req      (exc_req)
  );

  typedef struct {
    logic        req;
    logic [31:0] addr;
    logic [31:0] stat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_run  = 0;
  int          n_fail = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_stat = '0;
  bit          done   = 0;

  function automatic logic [31:0] stat_of(logic [1:0] m, logic w, logic [4:0] r);
    return 32'h1 | (32'(r) << 5) | (32'(w) << 10) | ((m == 2'd3) ? 32'h800 : 32'h0);
  endfunction

  // Driver: presents one access per cycle and predicts the outputs after the edge.
  task automatic drive(input logic v, input logic [31:0] a, input logic [1:0] m,
                       input logic w, input logic [4:0] r, input logic en, input string tag);
    exp_t e;
    logic bad;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_mask = m;
    acc_write = w; acc_reg = r; exc_enable = en;
    bad = v && ((a[1:0] & m) != 2'b00);
    if (bad) begin
      m_addr = a;
      m_stat = stat_of(m, w, r);
    end
    e.req = bad && en; e.addr = m_addr; e.stat = m_stat; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (exc_req !== e.req || fault_addr !== e.addr || fault_status !== e.stat) begin
          n_fail++;
          $display("FAIL %s: got req=%0b addr=%h stat=%h, expected req=%0b addr=%h stat=%h",
                   e.tag, exc_req, fault_addr, fault_status, e.req, e.addr, e.stat);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_addr = '0; acc_mask = '0;
    acc_write = 0; acc_reg = '0; exc_enable = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if (exc_req !== 1'b0 || fault_addr !== '0 || fault_status !== '0) begin
      n_fail++;
      $display("FAIL R8 reset: got req=%0b addr=%h stat=%h, expected all zero",
               exc_req, fault_addr, fault_status);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(0, 32'h0, 2'd0, 0, 5'd0, 1, "R8 idle after reset");
    drive(1, 32'h0000_0100, 2'd3, 0, 5'd3, 1, "R1 aligned word");
    drive(1, 32'h0000_1002, 2'd3, 1, 5'd7, 1, "R2/R3/R4 store word off2");
    drive(0, 32'h0000_0000, 2'd0, 0, 5'd0, 1, "R7 pulse ends, hold");
    drive(1, 32'h0000_2001, 2'd1, 0, 5'd31, 1, "R3/R4 load half odd");
    drive(1, 32'h0000_2002, 2'd1, 1, 5'd2, 1, "R1 aligned half, R7 hold");
    for (int k = 1; k < 4; k++)
      drive(1, 32'h8000_0000 | 32'(k), 2'd3, k[0], 5'(k + 10), 1, "R1 word offsets");
    drive(1, 32'hFFFF_FFFF, 2'd0, 1, 5'd9, 1, "R6 byte never flags");
    drive(1, 32'hABCD_0001, 2'd1, 1, 5'd5, 0, "R5 disabled still captures");
    drive(1, 32'h0000_0010, 2'd1, 0, 5'd1, 0, "R7 hold after disabled");
    drive(0, 32'h0000_0003, 2'd3, 1, 5'd17, 1, "R9 invalid ignored");
    drive(1, 32'h0000_0003, 2'd1, 0, 5'd0, 1, "R7 back-to-back first");
    drive(1, 32'h0000_0041, 2'd3, 1, 5'd31, 1, "R7 back-to-back second");
    drive(1, 32'h0000_0040, 2'd3, 0, 5'd4, 1, "R7 aligned after pair");
    drive(0, 32'h0, 2'd0, 0, 5'd0, 0, "R7 drain");
    repeat (3) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule